// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches page translations for a processor's memory pipeline. Each of its entries maps a 20-bit virtual page number to a 20-bit physical page number. An entry also carries a dirty flag, a write-enable flag, a user-access flag and an 8-bit process identifier. A lookup is combinational over the registered entries, so translation and the permission check finish in the same cycle. A lookup reports one of three results: a hit with the physical page, a miss, or a protection fault.

A page-table walker outside this block services misses. It writes the new translation through the fill port. The victim is the lowest-numbered invalid entry if one exists. Otherwise a round-robin pointer picks the victim.

A mode input chooses between two ways of handling a context switch:
- In flush mode, the process identifier is ignored, and a write to the page-directory base register clears every entry.
- In tagged mode, a hit also requires the identifier to match, and the base register write leaves the entries alone.

In both modes, a selective invalidation removes only the entries of one named process.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss and no hit, fault or dirty request.
- R2: With `lk_valid` high, exactly one of `lk_hit`/`lk_miss` is high, and a hit returns the physical page of the matching entry in the same cycle. With `lk_valid` low, both are low.
- R3: In tagged mode (`tagged_mode`=1), a hit needs the virtual page and `cur_pid` to both equal the entry's stored values. Fills store `cur_pid`, so one virtual page held for two processes gives two independent translations.
- R4: In flush mode (`tagged_mode`=0), the stored identifier is ignored on lookup, and a `pdbr_write` pulse invalidates every entry. In tagged mode, `pdbr_write` has no effect on the entries.
- R5: An `inv_valid` pulse invalidates exactly the entries whose stored identifier equals `inv_pid`, in either mode.
- R6: A fill whose page (and identifier, in tagged mode) matches a valid entry overwrites that entry in place. Otherwise the fill goes to the lowest-indexed invalid entry.
- R7: A fill that finds all entries valid and nothing matching replaces the entry at the round-robin pointer. The pointer is 0 after reset, advances by one on each such replacement, and wraps from the last entry to 0.
- R8: On a hit, `lk_fault` is high when `lk_user`=1 and the entry's user flag is 0 (a supervisor page), or when `lk_write`=1 and the entry's write flag is 0.
- R9: A write hit without fault on an entry with a clear dirty flag raises `lk_dirty_req` and sets the flag at the clock edge. Later write hits on that entry, or on an entry filled with `fill_dirty`=1, raise no request.
- R10: A flush or invalidation in the same cycle as a fill acts on the old contents. The newly filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tagged_mode | input | 1 | 1: identifier-tagged entries; 0: flush on base-register write |
| cur_pid | input | 8 | Identifier of the running process |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_user | input | 1 | Lookup is made in user mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_ppn | output | 20 | Physical page on a hit, zero otherwise |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_dirty_req | output | 1 | First permitted write to a clean page |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_writable | input | 1 | Page may be written |
| fill_user | input | 1 | Page is accessible from user mode |
| fill_dirty | input | 1 | Page is already dirty |
| pdbr_write | input | 1 | Page-directory base register written |
| inv_valid | input | 1 | Selective invalidation request |
| inv_pid | input | 8 | Identifier whose entries are dropped |

## Verification
Assertions check the following on every cycle:
- hit and miss are mutually exclusive;
- a fault or dirty request occurs only on a hit;
- at most one entry matches in tagged mode;
- a plain flush-mode base-register write empties the table;
- the round-robin pointer holds still unless a replacement occurs;
- a dirty request leaves the entry's flag set.

The bench scenarios cover what those properties cannot show on their own:
- which entry a fill lands in and which mapping gets evicted, including the pointer wrapping;
- that an invalidation spares other processes;
- that a fill survives a same-cycle flush;
- the full sweep of the permission and dirty combinations across every entry.

// File: rtl/ptlb_pkg.sv
// Package: shared widths and the entry record for the process-tagged TLB.
// Assumes every width here is fixed across one chip build.
package ptlb_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int PID_W = 8;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             writable;
        logic             user;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/ptlb_prio_enc.sv
// Priority encoder: returns the index of the lowest set bit of vec and a flag
// telling whether any bit is set. Assumes N >= 2.
module ptlb_prio_enc #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end

    // Reduction OR of the request vector.
    assign any = |vec;
endmodule

// File: rtl/ptlb_match.sv
// Compare array: one comparator per entry. The identifier is compared only
// when use_pid is high. Purely combinational.
module ptlb_match #(
    parameter int ENTRIES = 32
) (
    input  ptlb_pkg::tlb_entry_t            ent [ENTRIES],
    input  logic [ptlb_pkg::VPN_W-1:0]      vpn,
    input  logic [ptlb_pkg::PID_W-1:0]      pid,
    input  logic                            use_pid,
    output logic [ENTRIES-1:0]              match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Entry g matches when it is valid, the page agrees, and (if tagged) the identifier agrees.
        assign match[g] = ent[g].valid && (ent[g].vpn == vpn)
                          && (!use_pid || (ent[g].pid == pid));
    end
endmodule

// File: rtl/ptlb_victim.sv
// Victim picker: prefers the lowest invalid entry. When none is free it hands
// back the round-robin pointer and raises full.
module ptlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               full
);
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    ptlb_prio_enc #(.N(ENTRIES)) u_free_enc (
        .vec (~valid_vec),
        .idx (free_idx),
        .any (free_any)
    );

    // Choose a free slot first, else the pointer.
    assign victim = free_any ? free_idx : rr_ptr;
    assign full   = !free_any;
endmodule

// File: rtl/ptag_tlb.sv
// Fully associative, process-tagged translation cache with permission check.
// Lookup is combinational over registered entries. Fill, flush, invalidate
// and dirty-set take effect at the next rising edge.
// Assumes a mode change is accompanied by a flush, and that the walker
// fills only the translation a miss asked for.
module ptag_tlb #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int VPN_W = ptlb_pkg::VPN_W,
    localparam int PPN_W = ptlb_pkg::PPN_W,
    localparam int PID_W = ptlb_pkg::PID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tagged_mode,
    input  logic [PID_W-1:0] cur_pid,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_fault,
    output logic             lk_dirty_req,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_writable,
    input  logic             fill_user,
    input  logic             fill_dirty,
    input  logic             pdbr_write,
    input  logic             inv_valid,
    input  logic [PID_W-1:0] inv_pid
);
    import ptlb_pkg::*;

    tlb_entry_t         ent_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match, fl_match;
    logic [IDX_W-1:0]   hit_idx, fl_idx, vic_idx, tgt_idx;
    logic               lk_any, fl_any, tbl_full;
    logic               flush_all, replace_evt;
    tlb_entry_t         hit_ent, new_ent;

    // Gather the valid flags into a vector for the victim picker.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = ent_q[g].valid;
    end

    ptlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ent (ent_q), .vpn (lk_vpn), .pid (cur_pid),
        .use_pid (tagged_mode), .match (lk_match)
    );
    ptlb_prio_enc #(.N(ENTRIES)) u_lk_enc (
        .vec (lk_match), .idx (hit_idx), .any (lk_any)
    );
    ptlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .ent (ent_q), .vpn (fill_vpn), .pid (cur_pid),
        .use_pid (tagged_mode), .match (fl_match)
    );
    ptlb_prio_enc #(.N(ENTRIES)) u_fl_enc (
        .vec (fl_match), .idx (fl_idx), .any (fl_any)
    );
    ptlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_vec (valid_vec), .rr_ptr (rr_q),
        .victim (vic_idx), .full (tbl_full)
    );

    // Lookup result and the permission check, same cycle.
    always_comb begin
        hit_ent      = ent_q[hit_idx];
        lk_hit       = lk_valid && lk_any;
        lk_miss      = lk_valid && !lk_any;
        lk_ppn       = lk_hit ? hit_ent.ppn : '0;
        lk_fault     = lk_hit && ((lk_user && !hit_ent.user) ||
                                  (lk_write && !hit_ent.writable));
        lk_dirty_req = lk_hit && lk_write && !lk_fault && !hit_ent.dirty;
    end

    // Fill target, replacement event, and the record to be written.
    always_comb begin
        tgt_idx      = fl_any ? fl_idx : vic_idx;
        replace_evt  = fill_valid && !fl_any && tbl_full;
        flush_all    = pdbr_write && !tagged_mode;
        new_ent          = '0;
        new_ent.valid    = 1'b1;
        new_ent.dirty    = fill_dirty;
        new_ent.writable = fill_writable;
        new_ent.user     = fill_user;
        new_ent.pid      = cur_pid;
        new_ent.vpn      = fill_vpn;
        new_ent.ppn      = fill_ppn;
    end

    // Round-robin pointer: moves on replacement of a valid entry only.
    always_ff @(posedge clk) begin
        if (!rst_n)           rr_q <= '0;
        else if (replace_evt) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end

    // Per-entry update. Order: dirty set, then flush/invalidate, then fill.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                if (lk_dirty_req && hit_idx == IDX_W'(g)) ent_q[g].dirty <= 1'b1;
                if (flush_all || (inv_valid && ent_q[g].pid == inv_pid))
                    ent_q[g].valid <= 1'b0;
                if (fill_valid && tgt_idx == IDX_W'(g)) ent_q[g] <= new_ent;
            end
        end
    end

    // R2: hit and miss never together, neither without a request.
    a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));
    // R3: in tagged mode no two entries answer the same lookup.
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        tagged_mode |-> $onehot0(lk_match));
    // R4: a flush-mode base register write with no fill empties the table.
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (pdbr_write && !tagged_mode && !fill_valid) |=> (valid_vec == '0));
    // R7: the pointer stays put unless a full-table replacement happens.
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !replace_evt |=> $stable(rr_q));
    // R8: a fault is only reported on a hit.
    a_r8_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
    // R9: a dirty request comes from a permitted write hit.
    a_r9_dirty_req_ok: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dirty_req |-> (lk_hit && lk_write && !lk_fault));
    // R9: the requested entry carries its dirty flag afterwards.
    a_r9_dirty_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_dirty_req && !pdbr_write && !inv_valid && !fill_valid)
        |=> ent_q[$past(hit_idx)].dirty);
endmodule

// File: tb/ptag_tlb_tb.sv
module ptag_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tagged_mode = 1'b1;
    logic [7:0]  cur_pid = '0;
    logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty_req;
    logic [19:0] lk_ppn;
    logic        fill_valid = 1'b0, fill_writable = 1'b0, fill_user = 1'b0, fill_dirty = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        pdbr_write = 1'b0, inv_valid = 1'b0;
    logic [7:0]  inv_pid = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptag_tlb u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] v, input logic w, input logic u);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_write = w; lk_user = u;
        #2;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p,
                        input logic w, input logic u, input logic d);
        @(negedge clk);
        lk_valid = 1'b0;
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
        fill_writable = w; fill_user = u; fill_dirty = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic pulse_pdbr();
        @(negedge clk); lk_valid = 1'b0; pdbr_write = 1'b1;
        @(negedge clk); pdbr_write = 1'b0;
    endtask

    task automatic pulse_inv(input logic [7:0] p);
        @(negedge clk); lk_valid = 1'b0; inv_valid = 1'b1; inv_pid = p;
        @(negedge clk); inv_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] v, input logic [19:0] p);
        look(v, 1'b0, 1'b0);
        check(req, {31'b0, lk_hit}, 32'd1);
        check(req, {12'b0, lk_ppn}, {12'b0, p});
    endtask

    task automatic expect_miss(input string req, input logic [19:0] v);
        look(v, 1'b0, 1'b0);
        check(req, {31'b0, lk_miss}, 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic        dm [32];
        logic [19:0] ev [32];
        int          rr_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        look(20'h5, 1'b0, 1'b0);
        check("R1 miss", {31'b0, lk_miss}, 32'd1);
        check("R1 hit", {31'b0, lk_hit}, 32'd0);
        check("R1 fault", {31'b0, lk_fault}, 32'd0);
        expect_miss("R1 vpn0", 20'h0);

        // R3: tagged mode, same page for two processes.
        tagged_mode = 1'b1; cur_pid = 8'd1;
        fill(20'h5, 20'd100, 1'b1, 1'b1, 1'b0);
        cur_pid = 8'd2;
        expect_miss("R3 other pid", 20'h5);
        fill(20'h5, 20'd200, 1'b1, 1'b1, 1'b0);
        expect_hit("R3 pid2", 20'h5, 20'd200);
        cur_pid = 8'd1;
        expect_hit("R3 pid1", 20'h5, 20'd100);

        // R9: an entry filled dirty raises no request on write.
        fill(20'h7, 20'd77, 1'b1, 1'b1, 1'b1);
        look(20'h7, 1'b1, 1'b0);
        check("R9 prefilled dirty", {31'b0, lk_dirty_req}, 32'd0);

        // R4: tagged mode ignores the base register write.
        pulse_pdbr();
        expect_hit("R4 tagged keep", 20'h5, 20'd100);

        // R5: selective invalidation of process 1.
        pulse_inv(8'd1);
        expect_miss("R5 pid1 gone", 20'h5);
        cur_pid = 8'd2;
        expect_hit("R5 pid2 kept", 20'h5, 20'd200);

        // R4: flush mode, base register write clears all.
        tagged_mode = 1'b0;
        pulse_pdbr();
        expect_miss("R4 flushed", 20'h5);

        // R6/R8/R9: fill every entry, sweep permissions.
        for (int i = 0; i < 32; i++) begin
            cur_pid = 8'(i);
            fill(20'h1000 + 20'(i), 20'(i * 7 + 3), i[0], i[1], 1'b0);
            dm[i] = 1'b0;
        end
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic lw, lu, f, dr;
                lw = c[1]; lu = c[0];
                cur_pid = 8'(i + 40); // R4: identifier ignored in flush mode
                look(20'h1000 + 20'(i), lw, lu);
                f  = (lu && !i[1]) || (lw && !i[0]);
                dr = lw && !f && !dm[i];
                if (dr) dm[i] = 1'b1;
                check("R2 sweep hit", {31'b0, lk_hit}, 32'd1);
                check("R2 sweep ppn", {12'b0, lk_ppn}, 32'(i * 7 + 3));
                check("R8 fault", {31'b0, lk_fault}, {31'b0, f});
                check("R9 dirty req", {31'b0, lk_dirty_req}, {31'b0, dr});
            end
        end

        // R7: full table, pointer starts at 0.
        cur_pid = 8'hAA;
        fill(20'h2000, 20'd1, 1'b1, 1'b1, 1'b0);
        expect_miss("R7 evict e0", 20'h1000);
        expect_hit("R7 new e0", 20'h2000, 20'd1);
        expect_hit("R7 e1 kept", 20'h1001, 20'd10);
        fill(20'h2001, 20'd2, 1'b1, 1'b1, 1'b0);
        expect_miss("R7 evict e1", 20'h1001);
        // R6: overwrite in place, pointer unchanged.
        fill(20'h1005, 20'd555, 1'b1, 1'b1, 1'b0);
        expect_hit("R6 overwrite", 20'h1005, 20'd555);
        fill(20'h2002, 20'd3, 1'b1, 1'b1, 1'b0);
        expect_miss("R7 evict e2", 20'h1002);
        expect_hit("R6 e3 kept", 20'h1003, 20'd24);

        // R5 in flush mode, then R6 lowest free slot first.
        pulse_inv(8'd10);
        pulse_inv(8'd20);
        expect_miss("R5 pid10", 20'h100A);
        expect_miss("R5 pid20", 20'h1014);
        expect_hit("R5 pid11 kept", 20'h100B, 20'd80);
        fill(20'h3000, 20'd30, 1'b1, 1'b1, 1'b0);
        fill(20'h3001, 20'd31, 1'b1, 1'b1, 1'b0);
        expect_hit("R6 e3 still", 20'h1003, 20'd24);
        fill(20'h3002, 20'd32, 1'b1, 1'b1, 1'b0);
        expect_miss("R7 evict e3", 20'h1003);
        expect_hit("R7 e4 kept", 20'h1004, 20'd31);
        expect_hit("R6 free slot", 20'h3000, 20'd30);
        expect_hit("R6 free slot2", 20'h3001, 20'd31);

        // R10: fill in the same cycle as a flush survives.
        @(negedge clk);
        lk_valid = 1'b0;
        pdbr_write = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h4000; fill_ppn = 20'd44;
        fill_writable = 1'b1; fill_user = 1'b1; fill_dirty = 1'b0;
        @(negedge clk);
        pdbr_write = 1'b0; fill_valid = 1'b0;
        expect_hit("R10 fill kept", 20'h4000, 20'd44);
        expect_miss("R10 old gone", 20'h2000);
        expect_miss("R10 old gone2", 20'h1004);
        rr_exp = 5;

        // R7: wrap of the round-robin pointer.
        pulse_pdbr();
        for (int i = 0; i < 32; i++) begin
            fill(20'h5000 + 20'(i), 20'(i), 1'b1, 1'b1, 1'b0);
            ev[i] = 20'h5000 + 20'(i);
        end
        for (int j = 0; j < 40; j++) begin
            logic [19:0] gone;
            gone = ev[rr_exp];
            fill(20'h6000 + 20'(j), 20'(j + 500), 1'b1, 1'b1, 1'b0);
            ev[rr_exp] = 20'h6000 + 20'(j);
            rr_exp = (rr_exp + 1) % 32;
            expect_miss("R7 wrap evict", gone);
            expect_hit("R7 wrap new", 20'h6000 + 20'(j), 20'(j + 500));
        end

        // R2: no request, no result.
        @(negedge clk);
        lk_valid = 1'b0;
        #2;
        check("R2 idle hit", {31'b0, lk_hit}, 32'd0);
        check("R2 idle miss", {31'b0, lk_miss}, 32'd0);
        finish_run();
    end
endmodule